// File: doc/BRIEF.md
# Strip Channel Hit Timestamper

This block is the digital back end of one strip channel in a readout chip that runs without a trigger. It watches two discriminator outputs from the analog chain. The low-threshold comparator times the pulse. The high-threshold comparator confirms that the pulse is a real hit and not noise. A free-running timestamp bus is shared by every channel, and it advances once per clock.

Both comparator lines are first brought into the clock domain through a synchroniser. When the synchronised timing line rises, the current timestamp is stored as the arrival time. When the line falls, the block subtracts the stored arrival time from the current timestamp to get the time over threshold. It emits a record only if the confirming comparator was high during the pulse. The record carries the channel number, the arrival time and the time over threshold. It is offered to a region buffer over a valid/ready handshake. A pulse that starts while an earlier record is still waiting is discarded, and an overflow pulse reports the loss.

Top module: `strip_hit_stamper`

## Requirements
- R1: After reset, `rec_valid_o` and `ovf_o` are both 0.
- R2: With `ts_i` advancing by one per clock, the arrival time `rec_toa_o` equals the `ts_i` value present when `cmp_lo_i` went high, plus 2 modulo 2^14. The 2 is the synchroniser depth.
- R3: `rec_tot_o` is the falling-edge timestamp minus the rising-edge timestamp, taken modulo 2^14. A pulse L clocks wide gives L, and this holds even when `ts_i` wraps from 16383 to 0 during the pulse.
- R4: When that difference is 1024 or more, `rec_tot_o` saturates at 1023. A difference of 1023 is reported unchanged.
- R5: A pulse produces a record only if the synchronised `cmp_hi_i` is 1 on at least one cycle while the synchronised `cmp_lo_i` is 1. A pulse without this is dropped silently: there is no record and no `ovf_o`.
- R6: The confirmation state is cleared at every rising edge. A confirmed pulse does not confirm the next pulse, and `cmp_hi_i` being high only before the rise does not count.
- R7: While `rec_valid_o` is 1 and `rec_ready_i` is 0, `rec_valid_o` stays 1 and the channel, arrival-time and time-over-threshold fields do not change.
- R8: A rising edge seen while a record is waiting (`rec_valid_o`=1 and `rec_ready_i`=0) has three effects. That pulse is dropped. The waiting record is kept. `ovf_o` goes high for exactly one cycle.
- R9: `rec_chan_o` always equals the `CHAN_ID` parameter.
- R10: After a dropped pulse, the next pulse that starts while the output is free is captured normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the timestamp advances once per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmp_lo_i | input | 1 | Low-threshold (timing) comparator, asynchronous |
| cmp_hi_i | input | 1 | High-threshold (confirming) comparator, asynchronous |
| ts_i | input | TS_W (14) | Shared free-running timestamp |
| rec_ready_i | input | 1 | Region buffer accepts the record |
| rec_valid_o | output | 1 | A record is offered |
| rec_chan_o | output | CH_W (6) | Channel number |
| rec_toa_o | output | TS_W (14) | Arrival timestamp |
| rec_tot_o | output | TOT_W (10) | Saturated time over threshold |
| ovf_o | output | 1 | One-cycle pulse when a new pulse is dropped because the output is busy |

## Verification
The assertions assume the following about the inputs:
- A record can only first appear after the synchronised timing line has fallen, so the comparators must follow the one-pulse-at-a-time shape of a discriminator.
- `rec_ready_i` must be changed only between clock edges.

The stimulus holds to these assumptions in several ways:
- It drives every comparator change and every change of `rec_ready_i` on the falling clock edge.
- It keeps any gap between pulses at least two cycles long.
- It places each confirming window inside its own timing pulse, or entirely before the pulse, and ends such an early window no later than the cycle in which the timing line rises.
- It lets `ts_i` count freely from a random start, so a wrap of the timestamp is reached both by a directed test and by the random stream.

// File: rtl/shp_pkg.sv
package shp_pkg;
  // Per-pulse tracking state
  typedef enum logic [1:0] {
    PT_IDLE = 2'd0,   // timing line low
    PT_OPEN = 2'd1,   // pulse being timed, may be emitted
    PT_DROP = 2'd2    // pulse started while output busy, discarded
  } pulse_st_e;
endpackage

// File: rtl/shp_sync.sv
module shp_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] st_d;
    if (g == 0) begin : g_first
      assign st_d = d_i;
    end else begin : g_next
      assign st_d = st_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[g] <= '0;
      else        st_q[g] <= st_d;
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/shp_tracker.sv
module shp_tracker
  import shp_pkg::*;
#(
  parameter int TS_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lo_s_i,
  input  logic            hi_s_i,
  input  logic [TS_W-1:0] ts_i,
  input  logic            busy_i,
  output logic            fire_o,
  output logic [TS_W-1:0] toa_o,
  output logic            ovf_o
);
  pulse_st_e       st_q, st_n;
  logic            lo_d_q;
  logic            conf_q, conf_n;
  logic [TS_W-1:0] toa_q;
  logic            toa_en;
  logic            ovf_q, ovf_n;
  logic            rise, fall;

  assign rise = lo_s_i & ~lo_d_q;
  assign fall = ~lo_s_i & lo_d_q;

  always_comb begin
    st_n   = st_q;
    conf_n = conf_q;
    toa_en = 1'b0;
    ovf_n  = 1'b0;
    fire_o = 1'b0;
    if (rise) begin
      toa_en = 1'b1;
      conf_n = hi_s_i;
      if (busy_i) begin
        st_n  = PT_DROP;
        ovf_n = 1'b1;
      end else begin
        st_n  = PT_OPEN;
      end
    end else if (lo_s_i) begin
      conf_n = conf_q | hi_s_i;
    end
    if (fall) begin
      st_n   = PT_IDLE;
      fire_o = (st_q == PT_OPEN) & conf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PT_IDLE;
      lo_d_q <= 1'b0;
      conf_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      lo_d_q <= lo_s_i;
      conf_q <= conf_n;
      ovf_q  <= ovf_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      toa_q <= '0;
    else if (toa_en) toa_q <= ts_i;
  end

  assign toa_o = toa_q;
  assign ovf_o = ovf_q;

  AST_OVF_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> $past(busy_i));  // R8

  AST_DROPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PT_DROP) |-> !fire_o);  // R8
endmodule

// File: rtl/shp_recout.sv
module shp_recout #(
  parameter int TS_W  = 14,
  parameter int TOT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TS_W-1:0]  toa_i,
  input  logic [TS_W-1:0]  ts_now_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [TS_W-1:0]  toa_o,
  output logic [TOT_W-1:0] tot_o
);
  logic [TS_W-1:0]  diff;
  logic [TOT_W-1:0] tot_c;
  logic             valid_q, valid_n;
  logic [TS_W-1:0]  toa_q;
  logic [TOT_W-1:0] tot_q;

  assign diff = ts_now_i - toa_i;   // modulo 2^TS_W

  if (TS_W > TOT_W) begin : g_sat
    assign tot_c = (|diff[TS_W-1:TOT_W]) ? '1 : diff[TOT_W-1:0];
  end else begin : g_ext
    assign tot_c = TOT_W'(diff);
  end

  always_comb begin
    valid_n = valid_q;
    if (load_i)       valid_n = 1'b1;
    else if (ready_i) valid_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toa_q <= '0;
      tot_q <= '0;
    end else if (load_i) begin
      toa_q <= toa_i;
      tot_q <= tot_c;
    end
  end

  assign valid_o = valid_q;
  assign toa_o   = toa_q;
  assign tot_o   = tot_q;

  AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(toa_q) && $stable(tot_q)));  // R7

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !(valid_q && !ready_i));  // R8
endmodule

// File: rtl/strip_hit_stamper.sv
module strip_hit_stamper #(
  parameter int TS_W     = 14,
  parameter int TOT_W    = 10,
  parameter int CH_W     = 6,
  parameter int CHAN_ID  = 0,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_lo_i,
  input  logic             cmp_hi_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic             rec_ready_i,
  output logic             rec_valid_o,
  output logic [CH_W-1:0]  rec_chan_o,
  output logic [TS_W-1:0]  rec_toa_o,
  output logic [TOT_W-1:0] rec_tot_o,
  output logic             ovf_o
);
  localparam logic [CH_W-1:0] CHAN_VAL = CH_W'(CHAN_ID);

  logic [1:0]      cmp_s;
  logic            lo_s, hi_s;
  logic            busy;
  logic            fire;
  logic [TS_W-1:0] toa_held;

  shp_sync #(.STAGES(SYNC_STG), .W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cmp_hi_i, cmp_lo_i}),
    .q_o   (cmp_s)
  );

  assign lo_s = cmp_s[0];
  assign hi_s = cmp_s[1];
  assign busy = rec_valid_o & ~rec_ready_i;

  shp_tracker #(.TS_W(TS_W)) u_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .lo_s_i (lo_s),
    .hi_s_i (hi_s),
    .ts_i   (ts_i),
    .busy_i (busy),
    .fire_o (fire),
    .toa_o  (toa_held),
    .ovf_o  (ovf_o)
  );

  shp_recout #(.TS_W(TS_W), .TOT_W(TOT_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (fire),
    .toa_i    (toa_held),
    .ts_now_i (ts_i),
    .ready_i  (rec_ready_i),
    .valid_o  (rec_valid_o),
    .toa_o    (rec_toa_o),
    .tot_o    (rec_tot_o)
  );

  assign rec_chan_o = CHAN_VAL;

  AST_REC_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_valid_o) |-> ($past(lo_s) == 1'b0 && $past(lo_s, 2) == 1'b1));  // R3

  AST_CHAN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> (rec_chan_o == CHAN_VAL));  // R9
endmodule

// File: tb/sim_strip_hit_stamper.sv
`timescale 1ns/1ps
module sim_strip_hit_stamper;
  localparam int TS_W = 14, TOT_W = 10, CH_W = 6, CHID = 37;

  typedef struct {
    logic [CH_W-1:0]  ch;
    logic [TS_W-1:0]  toa;
    logic [TOT_W-1:0] tot;
  } rec_t;

  logic clk = 1'b0;
  logic rst_n;
  logic cmp_lo, cmp_hi, ready;
  logic [TS_W-1:0] ts;
  logic valid, ovf;
  logic [CH_W-1:0] chan;
  logic [TS_W-1:0] toa;
  logic [TOT_W-1:0] tot;

  int tests = 0, fails = 0, ovf_cnt = 0;
  bit done = 0;
  rec_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) ts <= ts + 1'b1;

  strip_hit_stamper #(.TS_W(TS_W), .TOT_W(TOT_W), .CH_W(CH_W), .CHAN_ID(CHID)) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_lo_i(cmp_lo), .cmp_hi_i(cmp_hi), .ts_i(ts),
    .rec_ready_i(ready), .rec_valid_o(valid), .rec_chan_o(chan), .rec_toa_o(toa),
    .rec_tot_o(tot), .ovf_o(ovf)
  );

  // Monitor: sample 1 ns after the falling edge, when the bench inputs have settled
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (valid && ready) begin
        rec_t r;
        r.ch = chan; r.toa = toa; r.tot = tot;
        q.push_back(r);
      end
      if (ovf) ovf_cnt++;
    end
  end

  function automatic logic [TS_W-1:0] exp_toa(logic [TS_W-1:0] t0);
    return t0 + TS_W'(2);
  endfunction

  function automatic logic [TOT_W-1:0] exp_tot(int len);
    return (len > 1023) ? TOT_W'(1023) : TOT_W'(len);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Timing pulse of len cycles; confirming line high on cycles [hoff, hoff+hlen) if hon
  task automatic run_pulse(int len, bit hon, int hoff, int hlen, output logic [TS_W-1:0] t0);
    @(negedge clk);
    t0 = ts;
    cmp_lo = 1'b1;
    cmp_hi = hon && (hoff == 0);
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      cmp_hi = hon && (i >= hoff) && (i < hoff + hlen);
    end
    @(negedge clk);
    cmp_lo = 1'b0;
    cmp_hi = 1'b0;
  endtask

  task automatic expect_rec(string req, logic [TS_W-1:0] t0, int len);
    check(q.size() == 1, {req, " record count"}, q.size(), 1);
    if (q.size() > 0) begin
      rec_t r = q.pop_front();
      check(r.ch == CH_W'(CHID), "R9 channel", r.ch, CHID);
      check(r.toa == exp_toa(t0), "R2 arrival time", r.toa, exp_toa(t0));
      check(r.tot == exp_tot(len), (len > 1023) ? "R4 saturated tot" : "R3 tot", r.tot, exp_tot(len));
    end
    q.delete();
  endtask

  task automatic expect_none(string req);
    check(q.size() == 0, req, q.size(), 0);
    q.delete();
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [TS_W-1:0] t0, ta;
    int ovf_base;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cmp_lo = 1'b0; cmp_hi = 1'b0; ready = 1'b1;
    ts = TS_W'($urandom);
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);
    #1;
    check(valid == 1'b0, "R1 valid after reset", valid, 0);
    check(ovf == 1'b0, "R1 ovf after reset", ovf, 0);

    // R3: timestamp wraps inside the pulse
    @(negedge clk); ts = 14'd16375;
    run_pulse(12, 1, 3, 2, t0);
    wait_cyc(6);
    expect_rec("R3 wrap", t0, 12);

    // R4: saturation boundary
    run_pulse(1023, 1, 500, 1, t0); wait_cyc(6); expect_rec("R4 at 1023", t0, 1023);
    run_pulse(1024, 1, 0, 1, t0);   wait_cyc(6); expect_rec("R4 at 1024", t0, 1024);
    run_pulse(1500, 1, 1499, 1, t0); wait_cyc(6); expect_rec("R4 at 1500", t0, 1500);

    // R5: no confirmation -> no record, no overflow
    run_pulse(20, 0, 0, 0, t0); wait_cyc(6); expect_none("R5 unconfirmed pulse");

    // R6: confirmation only before the rise does not count
    @(negedge clk); cmp_hi = 1'b1;
    wait_cyc(5);
    run_pulse(8, 0, 0, 0, t0); wait_cyc(6); expect_none("R6 early confirm ignored");

    // R6: confirmed pulse, then unconfirmed pulse right after
    run_pulse(6, 1, 2, 1, t0);
    wait_cyc(1);
    run_pulse(7, 0, 0, 0, ta);
    wait_cyc(6);
    expect_rec("R6 first pulse", t0, 6);

    // R7/R8: hold while not ready, drop second pulse
    ready = 1'b0;
    ovf_base = ovf_cnt;
    run_pulse(9, 1, 4, 3, t0);
    wait_cyc(6);
    #1;
    check(valid == 1'b1, "R7 valid held", valid, 1);
    check(toa == exp_toa(t0), "R7 toa held", toa, exp_toa(t0));
    check(tot == exp_tot(9), "R7 tot held", tot, exp_tot(9));
    run_pulse(5, 1, 0, 5, ta);
    wait_cyc(10);
    #1;
    check(valid == 1'b1, "R8 valid kept", valid, 1);
    check(toa == exp_toa(t0), "R8 toa kept", toa, exp_toa(t0));
    check(tot == exp_tot(9), "R8 tot kept", tot, exp_tot(9));
    check(ovf_cnt - ovf_base == 1, "R8 one overflow pulse", ovf_cnt - ovf_base, 1);
    @(negedge clk); ready = 1'b1;
    wait_cyc(4);
    expect_rec("R8 surviving record", t0, 9);

    // R10: capture resumes after a drop
    run_pulse(17, 1, 16, 1, t0); wait_cyc(6); expect_rec("R10 after drop", t0, 17);

    // Random stream, ready held high
    ovf_base = ovf_cnt;
    for (int n = 0; n < 250; n++) begin
      int len, hoff, hlen, gap;
      bit hon, pre;
      len  = ($urandom % 10 == 0) ? 900 + int'($urandom % 300) : 1 + int'($urandom % 40);
      hon  = ($urandom % 4) != 0;
      hoff = int'($urandom % len);
      hlen = 1 + int'($urandom % (len - hoff));
      pre  = ($urandom % 3) == 0;
      gap  = 2 + int'($urandom % 6);
      if (pre) begin
        @(negedge clk); cmp_hi = 1'b1;
        wait_cyc(gap - 1);
      end else begin
        wait_cyc(gap);
      end
      run_pulse(len, hon, hoff, hlen, t0);
      wait_cyc(6);
      if (hon) expect_rec("R2 random", t0, len);
      else     expect_none("R5 random unconfirmed");
    end
    check(ovf_cnt == ovf_base, "R8 no overflow when ready", ovf_cnt - ovf_base, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule